// File: doc/BRIEF.md
# Register-Mapped MDIO Management Master

This block is a management-bus master for Ethernet PHYs that a host controls through four registers: configuration/status, control, data and address. It generates the MDC clock and drives an MDIO line (split into output, output-enable and input pins for a pad or a tristate buffer at the chip level). Frames are never started by a dedicated command register. Each frame starts as a side effect of a register write. A data-register write sends a write frame. A control-register write with the read bit set sends a read frame. In the extended (Clause 45) encoding, an address-register write sends an address frame.

One configuration bit chooses between the Clause 22 and Clause 45 frame encodings. A second bit suppresses the preamble. A 9-bit field sets the MDC divider. In Clause 45 mode a register access takes two bus transactions: an address frame and then a data frame, both aimed at the port and device held in the control register. During a read the master releases the line from the first turnaround bit onward. It samples the second turnaround bit to detect whether a PHY is present, and shifts the 16 returned bits into the data register.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the status register reads 0x0280 (busy 0, read error 0, divider 5, both mode bits 0). Control, data and address read 0. MDC is low and the line is released.
- R2: The registers sit at word addresses 12 (status), 13 (control), 14 (data) and 15 (address), which are byte offsets 0x30 to 0x3C. Status fields: bit 0 busy, bit 1 read error, bit 5 preamble off, bit 6 Clause 45, bits 15:7 divider. Control fields: bits 4:0 device or register, bits 9:5 port, bit 15 start read (reads back 0). Any other word address reads 0.
- R3: A data-register write in Clause 22 mode sends start 01, opcode 01, port, register, turnaround 10 and the 16 data bits, MSB first, all driven by the master.
- R4: A Clause 22 read sends start 01 and opcode 10, then releases the line for the turnaround and data. When the frame completes, busy clears and the data register holds the 16 bits sampled from the PHY.
- R5: An address-register write in Clause 45 mode sends start 00, opcode 00, turnaround 10 and the address value. In Clause 22 mode the same write only stores the value and starts no frame.
- R6: In Clause 45 mode a data write uses start 00 and opcode 01, and a read uses start 00 and opcode 11.
- R7: With the preamble enabled a frame has 64 MDC periods, starting with 32 driven ones. With the preamble off it has 32.
- R8: One MDC period lasts 2·D+1 input clocks, with MDC high for D of them. MDIO changes only while MDC is low, and MDC stays low while the block is idle.
- R9: If the second turnaround bit of a read is sampled high, the read-error bit is set. The data register then holds whatever was sampled (0xFFFF with a pulled-up line).
- R10: Every register write while busy is ignored.
- R11: A divider value below 5 is stored and used as 5.
- R12: Read data stays in the data register until the host next writes it, which covers at least 16 MDC periods after busy clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_word | input | 6 | Word address of the register access |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench targets the read turnaround first. A design that kept driving the line during the turnaround, or sampled one bit off, would fill the data register with shifted bits, or miss an absent PHY and leave the error bit clear. It also sends an address-register write in Clause 22 mode, where a design that started a frame anyway would toggle MDC. It writes registers in the middle of a frame, where a design that accepted them would corrupt or replace the outgoing data. Finally it checks that a short divider is clamped, and measures the MDC high and low time and the total frame length both with the preamble on and with it off.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int DIV_MIN = 5,
  parameter int DIV_RST = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  reg_word,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int DIV_W = 9;
  localparam int CNT_W = DIV_W + 1;
  localparam int REM_W = 7;

  logic             busy_q, rd_q, err_q, pre_off_q, c45_q, mdc_q;
  logic [DIV_W-1:0] div_q;
  logic [4:0]       port_q, dev_q;
  logic [15:0]      data_q, addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [REM_W-1:0] rem_q;
  logic [63:0]      sh_q;

  logic wr_st, wr_ctl, wr_dat, wr_adr, go;
  assign wr_st  = reg_wr && !busy_q && reg_word == 6'd12;
  assign wr_ctl = reg_wr && !busy_q && reg_word == 6'd13;
  assign wr_dat = reg_wr && !busy_q && reg_word == 6'd14;
  assign wr_adr = reg_wr && !busy_q && reg_word == 6'd15;
  assign go     = wr_dat || (wr_adr && c45_q) || (wr_ctl && reg_wdata[15]);

  logic [1:0]  st_code, rd_op;
  logic [31:0] frm;
  assign st_code = c45_q ? 2'b00 : 2'b01;
  assign rd_op   = c45_q ? 2'b11 : 2'b10;
  always_comb begin
    if (wr_ctl)
      frm = {st_code, rd_op, reg_wdata[9:5], reg_wdata[4:0], 2'b11, 16'hFFFF};
    else if (wr_adr)
      frm = {2'b00, 2'b00, port_q, dev_q, 2'b10, reg_wdata};
    else
      frm = {st_code, 2'b01, port_q, dev_q, 2'b10, reg_wdata};
  end

  logic at_rise, at_wrap;
  assign at_rise = cnt_q == {1'b0, div_q};
  assign at_wrap = cnt_q == {div_q, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; rd_q <= 1'b0; err_q <= 1'b0; pre_off_q <= 1'b0; c45_q <= 1'b0;
      mdc_q <= 1'b0; div_q <= DIV_W'(DIV_RST); port_q <= '0; dev_q <= '0;
      data_q <= '0; addr_q <= '0; cnt_q <= '0; rem_q <= '0; sh_q <= '0;
    end else begin
      mdc_q <= busy_q && cnt_q >= {1'b0, div_q} && !at_wrap;
      if (busy_q) begin
        if (at_wrap) begin
          cnt_q <= '0;
          sh_q  <= {sh_q[62:0], 1'b1};
          rem_q <= rem_q - 1'b1;
          if (rem_q == 7'd1) busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        if (at_rise && rd_q) begin
          if (rem_q == 7'd17) err_q <= mdio_i;
          if (rem_q <= 7'd16) data_q <= {data_q[14:0], mdio_i};
        end
      end else begin
        if (wr_st) begin
          pre_off_q <= reg_wdata[5];
          c45_q     <= reg_wdata[6];
          div_q     <= (reg_wdata[15:7] < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : reg_wdata[15:7];
        end
        if (wr_ctl) begin
          dev_q  <= reg_wdata[4:0];
          port_q <= reg_wdata[9:5];
        end
        if (wr_dat) data_q <= reg_wdata;
        if (wr_adr) addr_q <= reg_wdata;
        if (go) begin
          busy_q <= 1'b1;
          rd_q   <= wr_ctl;
          err_q  <= 1'b0;
          cnt_q  <= '0;
          rem_q  <= pre_off_q ? 7'd32 : 7'd64;
          sh_q   <= pre_off_q ? {frm, 32'h0} : {32'hFFFF_FFFF, frm};
        end
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_oe = busy_q && !(rd_q && rem_q <= 7'd18);
  assign mdio_o  = mdio_oe ? sh_q[63] : 1'b1;

  always_comb begin
    case (reg_word)
      6'd12:   reg_rdata = {div_q, c45_q, pre_off_q, 3'b000, err_q, busy_q};
      6'd13:   reg_rdata = {6'b0, port_q, dev_q};
      6'd14:   reg_rdata = data_q;
      6'd15:   reg_rdata = addr_q;
      default: reg_rdata = '0;
    endcase
  end

  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdc);
  a_r8_change_low: assert property (@(posedge clk) disable iff (!rst_n)
    mdc && $past(mdc) |-> $stable(mdio_o));
  a_r8_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= {div_q, 1'b0});
  a_r7_rem_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q != 0 && rem_q <= 7'd64));
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) |-> $stable({div_q, c45_q, pre_off_q, port_q, dev_q, addr_q}));
  a_r9_err_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> rd_q);
  a_r11_div_min: assert property (@(posedge clk) disable iff (!rst_n)
    div_q >= DIV_W'(DIV_MIN));
endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] reg_word = 6'd0;
  logic reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  always #2 clk = ~clk;

  mdio_mgmt_master u_dut (.clk(clk), .rst_n(rst_n), .reg_word(reg_word), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  int tests = 0, fails = 0;
  int edge_k = 0;
  logic [63:0] cap_o, cap_oe, resp;

  always @(posedge mdc) begin
    #1;
    if (edge_k < 64) begin cap_o[edge_k] = mdio_o; cap_oe[edge_k] = mdio_oe; end
    edge_k = edge_k + 1;
    mdio_i = (edge_k < 64) ? resp[edge_k] : 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); reg_word = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); reg_word = a; #1 d = reg_rdata;
  endtask

  task automatic arm(input logic [63:0] r);
    edge_k = 0; resp = r; mdio_i = r[0]; cap_o = '0; cap_oe = '0;
  endtask

  task automatic wait_done(output int cyc, output int hi);
    cyc = 0; hi = 0;
    reg_word = 6'd12;
    #1;
    while (reg_rdata[0] === 1'b1 && cyc < 100000) begin
      cyc++;
      if (mdc) hi++;
      @(negedge clk); #1;
    end
  endtask

  // {kind[2:0], pre_off, present, port[4:0], dev[4:0], value[15:0]}
  // kind: 0 c22 write, 1 c22 read, 2 c45 address, 3 c45 write, 4 c45 read
  localparam logic [30:0] VEC [0:7] = '{
    {3'd0, 1'b0, 1'b1, 5'd1,  5'd2,  16'hA5C3},
    {3'd1, 1'b0, 1'b1, 5'd3,  5'd4,  16'h1234},
    {3'd2, 1'b0, 1'b1, 5'd5,  5'd1,  16'h8001},
    {3'd3, 1'b1, 1'b1, 5'd5,  5'd1,  16'hBEEF},
    {3'd4, 1'b0, 1'b1, 5'd31, 5'd30, 16'h5AA5},
    {3'd1, 1'b1, 1'b1, 5'd0,  5'd0,  16'h8001},
    {3'd4, 1'b1, 1'b0, 5'd9,  5'd17, 16'h0F0F},
    {3'd0, 1'b1, 1'b1, 5'd31, 5'd31, 16'hFFFF}
  };

  initial begin : wd
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int cyc, hi;
    arm('1);
    repeat (3) @(negedge clk);
    chk("R1 mdc low", {31'b0, mdc}, 0);
    chk("R1 oe low", {31'b0, mdio_oe}, 0);
    rst_n = 1'b1;
    rd(6'd12, v); chk("R1 status", v, 16'h0280);
    rd(6'd13, v); chk("R1 ctl", v, 0);
    rd(6'd14, v); chk("R1 data", v, 0);
    rd(6'd15, v); chk("R1 addr", v, 0);

    for (int i = 0; i < 8; i++) begin
      logic [2:0] kind; logic pre, pres; logic [4:0] port, dev; logic [15:0] val;
      logic rdk, c45; int len, off, mism; logic [31:0] frame; logic [1:0] op; logic [63:0] r;
      {kind, pre, pres, port, dev, val} = VEC[i];
      rdk = (kind == 3'd1) || (kind == 3'd4);
      c45 = kind >= 3'd2;
      len = pre ? 32 : 64; off = len - 32;
      case (kind)
        3'd0: op = 2'b01; 3'd1: op = 2'b10; 3'd2: op = 2'b00;
        3'd3: op = 2'b01; default: op = 2'b11;
      endcase
      frame = {c45 ? 2'b00 : 2'b01, op, port, dev, 2'b10, val};
      r = '1;
      if (rdk && pres) begin
        r[off + 15] = 1'b0;
        for (int b = 0; b < 16; b++) r[off + 16 + b] = val[15 - b];
      end
      wr(6'd12, {9'd5, c45, pre, 5'b0});
      wr(6'd13, {6'b0, port, dev});
      arm(r);
      case (kind)
        3'd0, 3'd3: wr(6'd14, val);
        3'd2:       wr(6'd15, val);
        default:    wr(6'd13, {1'b1, 5'b0, port, dev});
      endcase
      wait_done(cyc, hi);
      repeat (2) @(negedge clk);
      chk("R7 frame length", edge_k, len);
      mism = 0;
      for (int k = 0; k < len; k++) begin
        logic eo, eb;
        eo = !(rdk && k >= off + 14);
        eb = (k < off) ? 1'b1 : frame[31 - (k - off)];
        if (cap_oe[k] !== eo) mism++;
        else if (eo && cap_o[k] !== eb) mism++;
      end
      chk(kind == 3'd0 ? "R3 c22 write frame" : kind == 3'd1 ? "R4 c22 read frame" :
          kind == 3'd2 ? "R5 c45 address frame" : "R6 c45 frame", mism, 0);
      if (rdk) begin
        rd(6'd14, v); chk("R4 R9 read data", v, pres ? val : 16'hFFFF);
        rd(6'd12, v); chk("R9 read error bit", {31'b0, v[1]}, {31'b0, !pres});
      end
    end

    // R12: read data held for 16+ MDC periods
    repeat (16 * 11 + 4) @(negedge clk);
    rd(6'd14, v); chk("R12 data held", v, 16'hFFFF);

    // R2: field readback and unmapped address
    wr(6'd12, {9'd9, 1'b1, 1'b1, 5'b0});
    rd(6'd12, v); chk("R2 status fields", v, 16'h04E0);
    wr(6'd13, {1'b0, 5'b0, 5'h15, 5'h0A});
    rd(6'd13, v); chk("R2 ctl fields", v, 16'h02AA);
    rd(6'd0, v); chk("R2 unmapped", v, 0);

    // R11: divider clamp
    wr(6'd12, {9'd2, 7'b0});
    rd(6'd12, v); chk("R11 divider clamp", v, 16'h0280);

    // R5: address write in Clause 22 mode starts nothing
    arm('1);
    wr(6'd15, 16'h1234);
    repeat (40) @(negedge clk);
    chk("R5 no frame in c22", edge_k, 0);
    rd(6'd12, v); chk("R5 not busy", {31'b0, v[0]}, 0);
    rd(6'd15, v); chk("R5 addr stored", v, 16'h1234);

    // R10: writes during a frame ignored
    wr(6'd12, {9'd5, 1'b0, 1'b1, 5'b0});
    arm('1);
    wr(6'd14, 16'h1111);
    wr(6'd14, 16'h2222);
    wr(6'd12, {9'd31, 1'b1, 1'b0, 5'b0});
    wr(6'd13, 16'h8000);
    wait_done(cyc, hi);
    rd(6'd14, v); chk("R10 data kept", v, 16'h1111);
    rd(6'd12, v); chk("R10 status kept", v, 16'h02A0);
    rd(6'd13, v); chk("R10 ctl kept", v, 16'h02AA);

    // R8: MDC timing with divider 7, preamble off
    wr(6'd12, {9'd7, 1'b0, 1'b1, 5'b0});
    arm('1);
    wr(6'd14, 16'h00FF);
    wait_done(cyc, hi);
    chk("R8 frame clocks", cyc, 32 * 15);
    chk("R8 mdc high clocks", hi, 32 * 7);
    chk("R8 idle mdc", {31'b0, mdc}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule